// File: doc/BRIEF.md
# Paged ROM Bank-Select Controller

This block gives a 16-bit CPU access to more program ROM than its address map can hold. The lowest quarter of the map is a ROM window. A small page register chooses which 16 KB ROM page sits behind that window. The rest of the map, from 4000h upward, is decoded as RAM.

Software changes the page by writing the page number to any address inside the ROM window. The ROM cannot be written, so a write to the window is free to use as a command: the ROM stays off the bus and only the page register takes the value. The register resets to page 0, so the CPU always starts on the same page. The page count is a parameter. The default is four pages (64 KB), and three page bits give eight pages (128 KB).

The controller produces a ROM chip enable, a RAM chip enable, one-hot per-page enables, and the extended ROM address. A built-in ROM content model lets reads be checked without an external memory.

Top module: `paged_rom_ctrl`

## Requirements
- R1: `rom_ce_o` is high exactly when `addr_i[15:14]` is 00 (addresses 0000h to 3FFFh). `ram_ce_o` is high exactly for addresses 4000h to FFFFh.
- R2: When `wr_ni` is low and `rom_ce_o` is high at a rising clock edge, the page register loads the data. The new page applies to every access after that edge, including back-to-back writes on consecutive cycles.
- R3: A page write uses only `wdata_i[PAGE_BITS-1:0]`. All higher data bits are ignored.
- R4: An asynchronous low level on `rst_ni` clears the page register to 0 at once, and holds it at 0 while reset stays low, even if window writes are attempted.
- R5: Writes at 4000h and above, and reads anywhere, leave the page register unchanged.
- R6: `page_en_o` has bit number `page` set and no other bit while `rom_ce_o` is high. It is all zero while `rom_ce_o` is low.
- R7: `rom_addr_o` equals `{page, addr_i[13:0]}`. Its top `PAGE_BITS` bits are the page.
- R8: `rom_oe_o` is high only when `rom_ce_o` is high, `rd_ni` is low and `wr_ni` is high. During any write, `rom_oe_o` is 0 and `rom_rdata_o` is 0. Window writes never alter the ROM data read back later.
- R9: While `rom_oe_o` is high, `rom_rdata_o` is the XOR of the four bytes of the 32-bit zero-extended `rom_addr_o`. Otherwise it is 0.
- R10: `PAGE_BITS` sets the page count to 2**PAGE_BITS. With `PAGE_BITS`=3 the register holds values 0 to 7, taken from `wdata_i[2:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | CPU address |
| wdata_i | input | 8 | CPU write data |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low, sampled at the clock edge |
| rom_ce_o | output | 1 | ROM window selected |
| ram_ce_o | output | 1 | RAM region selected |
| page_en_o | output | 2**PAGE_BITS | One-hot page enable |
| rom_addr_o | output | PAGE_BITS+14 | Extended ROM address |
| rom_oe_o | output | 1 | ROM output enable |
| rom_rdata_o | output | 8 | ROM read data, 0 when not driven |

## Verification
The assertions assume that `wr_ni` and `addr_i` are stable around each rising clock edge, and that a write cycle is one clock long at the edge where it counts. They also assume that the CPU never drives `rd_ni` and `wr_ni` low together in a way that expects ROM data during a write. The bench changes every input only on falling edges and holds each write strobe low across exactly one rising edge. It never overlaps a read with a write that matters, and it raises the reset only on a falling edge. Both a four-page and an eight-page instance see the same stimulus.

// File: rtl/paged_rom_pkg.sv
package paged_rom_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned SEL_W  = 2;

  // XOR of the four bytes of a word: content of the ROM model
  function automatic logic [7:0] fold_bytes(input logic [31:0] v);
    return v[7:0] ^ v[15:8] ^ v[23:16] ^ v[31:24];
  endfunction
endpackage

// File: rtl/prom_addr_decode.sv
module prom_addr_decode #(
  parameter int unsigned SEL_W = 2
) (
  input  logic [SEL_W-1:0] sel_i,
  output logic             win_o,
  output logic             ram_o
);
  always_comb begin
    win_o = (sel_i == '0);
    ram_o = !win_o;
  end
endmodule

// File: rtl/prom_page_reg.sv
module prom_page_reg #(
  parameter int unsigned PAGE_BITS = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic [PAGE_BITS-1:0] page_i,
  output logic [PAGE_BITS-1:0] page_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     page_o <= '0;
    else if (load_i) page_o <= page_i;
  end
endmodule

// File: rtl/prom_page_onehot.sv
module prom_page_onehot #(
  parameter int unsigned PAGE_BITS = 2,
  localparam int unsigned NUM_PAGES = 1 << PAGE_BITS
) (
  input  logic [PAGE_BITS-1:0] page_i,
  input  logic                 en_i,
  output logic [NUM_PAGES-1:0] onehot_o
);
  for (genvar g = 0; g < NUM_PAGES; g++) begin : g_pg
    assign onehot_o[g] = en_i && (page_i == PAGE_BITS'(g));
  end
endmodule

// File: rtl/prom_rom_model.sv
module prom_rom_model
  import paged_rom_pkg::*;
#(
  parameter int unsigned EXT_W = 16
) (
  input  logic [EXT_W-1:0]  ext_addr_i,
  input  logic              oe_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [31:0] wide;
  always_comb begin
    wide    = 32'(ext_addr_i);
    rdata_o = oe_i ? fold_bytes(wide) : '0;
  end
endmodule

// File: rtl/paged_rom_ctrl.sv
module paged_rom_ctrl
  import paged_rom_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned PAGE_BITS = 2,
  localparam int unsigned WIN_W     = ADDR_W - SEL_W,
  localparam int unsigned NUM_PAGES = 1 << PAGE_BITS,
  localparam int unsigned EXT_W     = PAGE_BITS + WIN_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  input  logic                 rd_ni,
  input  logic                 wr_ni,
  output logic                 rom_ce_o,
  output logic                 ram_ce_o,
  output logic [NUM_PAGES-1:0] page_en_o,
  output logic [EXT_W-1:0]     rom_addr_o,
  output logic                 rom_oe_o,
  output logic [DATA_W-1:0]    rom_rdata_o
);
  logic                 win;
  logic                 page_load;
  logic [PAGE_BITS-1:0] page;
  logic                 unused_hi;

  assign unused_hi = ^wdata_i[DATA_W-1:PAGE_BITS];

  prom_addr_decode #(.SEL_W(SEL_W)) u_dec (
    .sel_i (addr_i[ADDR_W-1 -: SEL_W]),
    .win_o (win),
    .ram_o (ram_ce_o)
  );

  // a write into the read-only window is the page command
  assign page_load = win && !wr_ni;

  prom_page_reg #(.PAGE_BITS(PAGE_BITS)) u_page (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (page_load),
    .page_i (wdata_i[PAGE_BITS-1:0]),
    .page_o (page)
  );

  prom_page_onehot #(.PAGE_BITS(PAGE_BITS)) u_oh (
    .page_i   (page),
    .en_i     (win),
    .onehot_o (page_en_o)
  );

  assign rom_ce_o   = win;
  assign rom_addr_o = {page, addr_i[WIN_W-1:0]};
  // ROM stays off the bus during any write
  assign rom_oe_o   = win && !rd_ni && wr_ni;

  prom_rom_model #(.EXT_W(EXT_W)) u_rom (
    .ext_addr_i (rom_addr_o),
    .oe_i       (rom_oe_o),
    .rdata_o    (rom_rdata_o)
  );
endmodule

// File: rtl/paged_rom_ctrl_chk.sv
module paged_rom_ctrl_chk #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned PAGE_BITS = 2,
  localparam int unsigned WIN_W     = ADDR_W - 2,
  localparam int unsigned NUM_PAGES = 1 << PAGE_BITS,
  localparam int unsigned EXT_W     = PAGE_BITS + WIN_W
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [ADDR_W-1:0]    addr_i,
  input logic [7:0]           wdata_i,
  input logic                 rd_ni,
  input logic                 wr_ni,
  input logic                 rom_ce_o,
  input logic                 ram_ce_o,
  input logic [NUM_PAGES-1:0] page_en_o,
  input logic [EXT_W-1:0]     rom_addr_o,
  input logic                 rom_oe_o,
  input logic [7:0]           rom_rdata_o
);
  logic [PAGE_BITS-1:0] cur_page;
  assign cur_page = rom_addr_o[EXT_W-1 -: PAGE_BITS];

  assert_ce_exclusive_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_ce_o != ram_ce_o);

  assert_page_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rom_ce_o && !wr_ni) |=> cur_page == $past(wdata_i[PAGE_BITS-1:0]));

  assert_page_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rom_ce_o && !wr_ni) |=> $stable(cur_page));

  assert_onehot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_ce_o |-> ($countones(page_en_o) == 1 && page_en_o[cur_page]));

  assert_idle_en_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rom_ce_o |-> page_en_o == '0);

  assert_low_addr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_addr_o[WIN_W-1:0] == addr_i[WIN_W-1:0]);

  assert_no_drive_on_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_ni |-> (!rom_oe_o && rom_rdata_o == 8'h00));

  assert_oe_qual_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_oe_o |-> (rom_ce_o && !rd_ni));
endmodule

bind paged_rom_ctrl paged_rom_ctrl_chk #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .rd_ni       (rd_ni),
  .wr_ni       (wr_ni),
  .rom_ce_o    (rom_ce_o),
  .ram_ce_o    (ram_ce_o),
  .page_en_o   (page_en_o),
  .rom_addr_o  (rom_addr_o),
  .rom_oe_o    (rom_oe_o),
  .rom_rdata_o (rom_rdata_o)
);

// File: tb/paged_rom_ctrl_test.sv
module paged_rom_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic [7:0]  wdata = 8'h00;
  logic        rd_n = 1'b1;
  logic        wr_n = 1'b1;

  logic        ce_a, ram_a, oe_a;
  logic [3:0]  en_a;
  logic [15:0] xa_a;
  logic [7:0]  rd_a;
  logic        ce_b, ram_b, oe_b;
  logic [7:0]  en_b;
  logic [16:0] xa_b;
  logic [7:0]  rd_b;

  int checks = 0;
  int fails  = 0;
  int exp_a  = 0;
  int exp_b  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  paged_rom_ctrl #(.PAGE_BITS(2)) uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .rd_ni(rd_n), .wr_ni(wr_n), .rom_ce_o(ce_a), .ram_ce_o(ram_a),
    .page_en_o(en_a), .rom_addr_o(xa_a), .rom_oe_o(oe_a), .rom_rdata_o(rd_a));

  paged_rom_ctrl #(.PAGE_BITS(3)) uut_wide (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .rd_ni(rd_n), .wr_ni(wr_n), .rom_ce_o(ce_b), .ram_ce_o(ram_b),
    .page_en_o(en_b), .rom_addr_o(xa_b), .rom_oe_o(oe_b), .rom_rdata_o(rd_b));

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic int fold(input int e);
    return (e & 255) ^ ((e >> 8) & 255) ^ ((e >> 16) & 255) ^ ((e >> 24) & 255);
  endfunction

  task automatic check_pages(input string req);
    chk(int'(xa_a[15:14]) == exp_a, req, int'(xa_a[15:14]), exp_a);
    chk(int'(xa_b[16:14]) == exp_b, {req, "/R10"}, int'(xa_b[16:14]), exp_b);
  endtask

  // read one address and check every output of both instances
  task automatic read_at(input int a);
    int win, ea, eb;
    @(negedge clk);
    addr = 16'(a); rd_n = 1'b0; wr_n = 1'b1;
    #1;
    win = ((a >> 14) == 0) ? 1 : 0;
    ea  = (exp_a << 14) | (a & 16'h3FFF);
    eb  = (exp_b << 14) | (a & 16'h3FFF);
    chk(int'(ce_a) == win && int'(ram_a) == 1 - win, "R1", int'({ce_a, ram_a}), win * 2 + 1 - win);
    chk(int'(en_a) == (win ? (1 << exp_a) : 0), "R6", int'(en_a), win ? (1 << exp_a) : 0);
    chk(int'(xa_a) == ea, "R7", int'(xa_a), ea);
    chk(int'(oe_a) == win, "R8", int'(oe_a), win);
    chk(int'(rd_a) == (win ? fold(ea) : 0), "R9", int'(rd_a), win ? fold(ea) : 0);
    chk(int'(en_b) == (win ? (1 << exp_b) : 0), "R10", int'(en_b), win ? (1 << exp_b) : 0);
    chk(int'(xa_b) == eb, "R10", int'(xa_b), eb);
    chk(int'(rd_b) == (win ? fold(eb) : 0), "R10", int'(rd_b), win ? fold(eb) : 0);
  endtask

  task automatic write_at(input int a, input int d);
    @(negedge clk);
    addr = 16'(a); wdata = 8'(d); wr_n = 1'b0; rd_n = 1'b1;
    #1;
    chk(!oe_a && rd_a == 8'h00 && !oe_b && rd_b == 8'h00, "R8", int'({oe_a, rd_a}), 0);
    @(negedge clk);
    wr_n = 1'b1;
    if ((a >> 14) == 0) begin
      exp_a = d & 3;
      exp_b = d & 7;
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // reset state
    repeat (3) @(negedge clk);
    addr = 16'h1234;
    #1;
    check_pages("R4");
    chk(xa_a == 16'h1234, "R7", int'(xa_a), 16'h1234);
    @(negedge clk);
    rst_n = 1'b1;

    // every page, high data bits set to junk, several window addresses
    for (int p = 0; p < 8; p++) begin
      int d;
      d = ((p % 2) ? 8'hB0 : 8'h48) | p;
      write_at((p * 16'h0777) & 16'h3FFF, d);
      @(negedge clk); #1;
      check_pages("R2/R3");
      for (int a = p; a < 65536; a += 97) read_at(a);
      read_at(16'h3FFF);
      read_at(16'h4000);
    end

    // back-to-back window writes
    @(negedge clk);
    addr = 16'h0000; wr_n = 1'b0; wdata = 8'h05;
    @(negedge clk);
    exp_a = 1; exp_b = 5;
    #1; check_pages("R2");
    wdata = 8'hFA;
    @(negedge clk);
    wr_n = 1'b1;
    exp_a = 2; exp_b = 2;
    #1; check_pages("R2");

    // RAM writes leave page alone
    write_at(16'h4000, 8'h07);
    write_at(16'hFFFF, 8'h01);
    write_at(16'h8123, 8'h04);
    @(negedge clk); #1;
    check_pages("R5");
    for (int i = 0; i < 5; i++) read_at(16'h0100 + i);
    check_pages("R5");

    // ROM contents unchanged after window writes
    write_at(16'h2000, 8'h03);
    write_at(16'h2000, 8'hFF);
    read_at(16'h2000);
    read_at(16'h3FFE);

    // asynchronous reset mid-cycle, writes attempted while held
    @(posedge clk); #2;
    rst_n = 1'b0;
    #1;
    exp_a = 0; exp_b = 0;
    check_pages("R4");
    @(negedge clk);
    addr = 16'h0010; wdata = 8'h06; wr_n = 1'b0;
    @(negedge clk); #1;
    check_pages("R4");
    wr_n = 1'b1;
    rst_n = 1'b1;
    read_at(16'h0010);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule